// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers seven interrupt causes of a serial peripheral into one interrupt line. Three causes are events: receive overflow, mode fault and transmit underflow. Each arrives as a single-cycle pulse and is latched into a status bit that stays set until software clears it. The other four causes are FIFO flags: transmit not full, transmit full, receive not empty and receive full. These are levels, and their status bits show the flag as it is now.

Software works through a small register port. A write with data bit i set to 1 at the clear-status offset clears sticky bit i. Two write-only registers change the mask. Ones written to the enable offset add bits to the mask, and ones written to the disable offset remove them. The mask itself can be read at its own offset. The interrupt output is a registered OR of status AND mask.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the sticky status bits and the mask are zero and `irqOut` is low.
- R2: Status reads at offset 0x04 and has this bit layout: 0 receive overflow, 1 mode fault, 2 transmit not full, 3 transmit full, 4 receive not empty, 5 receive full, 6 transmit underflow. Bits 31..7 read zero.
- R3: Bits 0, 1 and 6 are sticky. A 1 on the matching `srcIn` bit at a clock edge sets the bit, and it stays set until it is cleared.
- R4: A write at offset 0x04 clears each sticky bit whose data bit is 1 and leaves the sticky bits whose data bit is 0 unchanged. Writing all ones clears every sticky bit.
- R5: Status bits 2..5 show `srcIn[5:2]` in the same cycle. Writes to these bits have no effect.
- R6: A write at offset 0x08 sets each mask bit whose data bit is 1. Zero data bits leave the mask unchanged.
- R7: A write at offset 0x0C clears each mask bit whose data bit is 1. Zero data bits leave the mask unchanged.
- R8: The mask reads at offset 0x10 and resets to zero. Reads at 0x08, at 0x0C and at any unmapped offset return zero.
- R9: `irqOut` is registered. After each clock edge it equals the OR of (status AND mask) as that status and mask stood before the edge.
- R10: If an event pulse and a clearing write reach the same sticky bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 7 | Cause inputs: pulses on bits 0, 1 and 6, levels on bits 2..5 |
| busWe | input | 1 | Write strobe for the register port |
| busAddr | input | 8 | Byte offset for the read or the write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench drives a clearing write in the same cycle as a pulse on the same bit. A design that let the clear win would lose an overflow, and the next status read would show the bit low. It writes ones to live bits 2..5 and to zero bits of the enable and disable registers. A design that stored those writes or treated a zero as a command would change what status or the mask reads back. It checks `irqOut` one edge after each change of cause or mask. A design that was combinational or one cycle late would be caught there. It also reads the write-only offsets, which must return zero, so a design that returned the mask at those offsets would show a mismatch.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int OFF_STATUS  = 'h04;
  localparam int OFF_ENABLE  = 'h08;
  localparam int OFF_DISABLE = 'h0C;
  localparam int OFF_MASK    = 'h10;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_MASK
  } rdSelT;

  typedef struct packed {
    logic statusClr;
    logic maskSet;
    logic maskClr;
  } strobeT;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobeT            strobes,
  output rdSelT             rdSel
);

  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(OFF_DISABLE);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFF_MASK);

  always_comb begin
    strobes.statusClr = busWe && (busAddr == A_STATUS);
    strobes.maskSet   = busWe && (busAddr == A_ENABLE);
    strobes.maskClr   = busWe && (busAddr == A_DISABLE);
  end

  // Enable and disable are write-only, so they fall through to RD_NONE.
  always_comb begin
    unique case (busAddr)
      A_STATUS: rdSel = RD_STATUS;
      A_MASK:   rdSel = RD_MASK;
      default:  rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int                NUM_SRC     = 7,
  parameter int                DATA_W      = 32,
  parameter logic [NUM_SRC-1:0] STICKY_MASK = 7'b1000011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  strobeT             strobes,
  input  rdSelT              rdSel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] statusVis,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqQ
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] offVec;
  logic               unusedWdataHi;

  assign wbits         = wdata[NUM_SRC-1:0];
  assign unusedWdataHi = ^wdata[DATA_W-1:NUM_SRC];
  assign clrVec        = strobes.statusClr ? wbits : '0;
  assign setVec        = strobes.maskSet   ? wbits : '0;
  assign offVec        = strobes.maskClr   ? wbits : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      logic flagQ;
      // A pulse in the same cycle as a clear keeps the bit set.
      always_ff @(posedge clk) begin
        if (!rstN) flagQ <= 1'b0;
        else       flagQ <= (flagQ & ~clrVec[i]) | srcIn[i];
      end
      assign statusVis[i] = flagQ;
    end else begin : g_live
      assign statusVis[i] = srcIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= '0;
    else       maskQ <= (maskQ | setVec) & ~offVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusVis & maskQ);
  end

  always_comb begin
    unique case (rdSel)
      RD_STATUS: rdata = {{PAD_W{1'b0}}, statusVis};
      RD_MASK:   rdata = {{PAD_W{1'b0}}, maskQ};
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int                NUM_SRC     = 7,
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 32,
  parameter logic [NUM_SRC-1:0] STICKY_MASK = 7'b1000011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);

  strobeT             strobes;
  rdSelT              rdSel;
  logic [NUM_SRC-1:0] statusVis;
  logic [NUM_SRC-1:0] maskQ;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  irq_agg_datapath #(
    .NUM_SRC     (NUM_SRC),
    .DATA_W      (DATA_W),
    .STICKY_MASK (STICKY_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .strobes   (strobes),
    .rdSel     (rdSel),
    .wdata     (busWdata),
    .statusVis (statusVis),
    .maskQ     (maskQ),
    .rdata     (busRdata),
    .irqQ      (irqOut)
  );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int                NUM_SRC     = 7,
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 32,
  parameter logic [NUM_SRC-1:0] STICKY_MASK = 7'b1000011
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] statusVis,
  input logic [NUM_SRC-1:0] maskQ
);

  logic [NUM_SRC-1:0] clrReq;
  logic [NUM_SRC-1:0] enReq;
  logic [NUM_SRC-1:0] disReq;

  assign clrReq = (busWe && busAddr == ADDR_W'(OFF_STATUS))  ? busWdata[NUM_SRC-1:0] : '0;
  assign enReq  = (busWe && busAddr == ADDR_W'(OFF_ENABLE))  ? busWdata[NUM_SRC-1:0] : '0;
  assign disReq = (busWe && busAddr == ADDR_W'(OFF_DISABLE)) ? busWdata[NUM_SRC-1:0] : '0;

  // R9: the interrupt line follows status AND mask one edge later.
  a_r9_irq_registered: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(statusVis & maskQ))));

  // R3: a set sticky bit that is not cleared stays set.
  a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusVis) & STICKY_MASK & ~$past(clrReq)) & ~statusVis) == '0));

  // R10: an event pulse always leaves its sticky bit set, even under a clear.
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(srcIn) & STICKY_MASK) & ~statusVis) == '0));

  // R6: enable writes set their mask bits.
  a_r6_enable_sets: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(enReq) & ~$past(disReq) & ~maskQ) == '0));

  // R7: disable writes clear their mask bits.
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(disReq) & maskQ) == '0));

  // R6, R7: without an enable or disable write the mask holds.
  a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rstN)
    (enReq == '0 && disReq == '0) |=> $stable(maskQ));

endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_SRC     (NUM_SRC),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .STICKY_MASK (STICKY_MASK)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .srcIn     (srcIn),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .irqOut    (irqOut),
  .statusVis (statusVis),
  .maskQ     (maskQ)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

  localparam logic [6:0] STICKY = 7'b1000011;
  localparam logic [6:0] LIVE   = 7'b0111100;
  localparam logic [7:0] A_ST   = 8'h04;
  localparam logic [7:0] A_EN   = 8'h08;
  localparam logic [7:0] A_DIS  = 8'h0C;
  localparam logic [7:0] A_MSK  = 8'h10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [6:0]  srcIn;
  logic        busWe;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [6:0] stickyM;
  logic [6:0] maskM;
  logic       irqM;

  always #2 clk = ~clk;

  irq_aggregator u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  function automatic logic [31:0] expRead(logic [7:0] a, logic [6:0] s);
    if (a == A_ST)  return {25'd0, stickyM | (s & LIVE)};
    if (a == A_MSK) return {25'd0, maskM};
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check the read, clock, check irq.
  task automatic step(logic we, logic [7:0] a, logic [31:0] d, logic [6:0] s, string req);
    logic [6:0] vis;
    logic [6:0] clr;
    busWe = we; busAddr = a; busWdata = d; srcIn = s;
    #1;
    if (!we) chk(req, busRdata, expRead(a, s));
    vis = stickyM | (s & LIVE);
    clr = (we && a == A_ST) ? d[6:0] : 7'd0;
    @(posedge clk);
    irqM    = |(vis & maskM);
    stickyM = ((stickyM & ~clr) | s) & STICKY;
    if (we && a == A_EN)  maskM = maskM | d[6:0];
    if (we && a == A_DIS) maskM = maskM & ~d[6:0];
    @(negedge clk);
    chk("R9 irq", {31'd0, irqOut}, {31'd0, irqM});
  endtask

  initial begin
    #400000;
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0]  a;
    logic [31:0] d;
    logic [6:0]  lv;
    logic [6:0]  s;
    void'($urandom(32'd1234));
    rstN = 1'b0; srcIn = '0; busWe = 0; busAddr = '0; busWdata = '0;
    stickyM = '0; maskM = '0; irqM = 0;
    repeat (3) @(negedge clk);
    chk("R1 irq reset", {31'd0, irqOut}, 32'd0);
    rstN = 1'b1;
    step(0, A_ST, 0, 7'd0, "R1 status reset");
    step(0, A_MSK, 0, 7'd0, "R8 mask reset");

    // R3 sticky set and hold
    step(0, A_ST, 0, 7'b1000011, "R3 pre");
    step(0, A_ST, 0, 7'd0, "R3 sticky held");
    // R5 live bits and ignored writes
    step(1, A_ST, 32'h0000_003C, 7'b0111100, "R5 write");
    step(0, A_ST, 0, 7'b0010100, "R5 live bits");
    // R4 partial clear then all ones
    step(1, A_ST, 32'h0000_0001, 7'd0, "R4 w");
    step(0, A_ST, 0, 7'd0, "R4 partial clear");
    step(1, A_ST, 32'hFFFF_FFFF, 7'd0, "R4 w");
    step(0, A_ST, 0, 7'd0, "R4 all ones clear");
    // R10 collision
    step(1, A_ST, 32'hFFFF_FFFF, 7'b1000000, "R10 w");
    step(0, A_ST, 0, 7'd0, "R10 event wins");
    // R6/R7 enable and disable with zero bits
    step(1, A_EN, 32'h0000_0041, 7'd0, "R6 w");
    step(0, A_MSK, 0, 7'd0, "R6 mask set");
    step(1, A_EN, 32'h0000_0000, 7'd0, "R6 w0");
    step(0, A_MSK, 0, 7'd0, "R6 zero no effect");
    step(1, A_DIS, 32'h0000_0001, 7'd0, "R7 w");
    step(0, A_MSK, 0, 7'd0, "R7 mask clear");
    step(0, A_EN, 0, 7'd0, "R8 enable reads zero");
    step(0, A_DIS, 0, 7'd0, "R8 disable reads zero");
    step(0, 8'h20, 0, 7'd0, "R8 unmapped reads zero");
    // R9 live level drives irq
    step(1, A_EN, 32'h0000_0010, 7'd0, "R9 w");
    step(0, A_ST, 0, 7'b0010000, "R9 level");
    step(0, A_ST, 0, 7'd0, "R9 level drop");
    step(1, A_DIS, 32'hFFFF_FFFF, 7'd0, "R7 all");
    step(1, A_ST, 32'hFFFF_FFFF, 7'd0, "R4 all");

    lv = '0;
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(15) == 0) lv = 7'($urandom) & LIVE;
      s = lv;
      for (int b = 0; b < 7; b++)
        if (STICKY[b] && $urandom_range(7) == 0) s[b] = 1'b1;
      case ($urandom_range(5))
        0: a = A_ST; 1: a = A_EN; 2: a = A_DIS; 3: a = A_MSK;
        4: a = 8'($urandom_range(31) << 2);
        default: a = A_ST;
      endcase
      d = ($urandom_range(9) == 0) ? 32'hFFFF_FFFF : $urandom;
      step($urandom_range(1) == 1, a, d, s, "R2 R3 R4 R6 R7 R8 random read");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule